// File: doc/BRIEF.md
# Mirrored-Bank Parity Fallback Memory

A synchronous single-port word memory that can run in two modes, chosen per request by a mode input. In full-capacity mode every address reaches its own word, and read data is returned exactly as stored. In protected mode the array acts as two mirrored halves. The lower half is the primary bank and the upper half is the secondary bank. Each write lands in both halves. On a read, every 9-bit lane of the primary word is checked for odd parity, and any lane that fails is replaced by the same lane from the secondary word.

Writes pass through a one-entry write stage. A write accepted on one clock edge is committed to the array on the next edge. A read of the same word in the cycle in between takes the pending lanes straight from that stage and does not check their parity. A per-lane flag vector returned with each read shows which lanes came from the secondary bank. For test, a corrupt port XORs a flip pattern into any primary-bank word without going through the write stage.

Top module: `mbpf_mem`

## Requirements
- R1: After reset, rd_valid and rd_fallback are both 0 until the first read request has been sampled.
- R2: With mode_full=1, all 2^ADDR_W addresses hold independent words. A read returns the stored word unchanged, whatever its parity, and rd_fallback is 0.
- R3: With mode_full=0, the top bit of req_addr is ignored. Two addresses that differ only in that bit reach the same stored word.
- R4: A write with mode_full=0 stores its lanes both at the primary index (top address bit 0) and at the secondary index (top address bit 1). A later full-capacity read of either address returns the written data.
- R5: Lane l occupies bits [9l+8:9l] of the word. In protected mode a primary lane passes the check when it holds an odd number of ones.
- R6: In protected mode, each primary lane with an even number of ones is replaced by the matching secondary lane. Lanes that pass keep their primary data, and the choice is made for each lane on its own.
- R7: Secondary lanes are never checked. A secondary lane with even parity is still returned when its primary lane fails.
- R8: A write accepted on one edge is pending until the next edge. A read sampled on that next edge, at the same bank index, returns the pending enabled lanes as written, unchecked, with their fallback bits clear.
- R9: A read request sampled on a clock edge gives rd_valid=1 and its data after that same edge, for one cycle. A write request or an idle cycle gives rd_valid=0.
- R10: rd_fallback bit l is 1 exactly when lane l of the returned word came from the secondary bank. It is all zero whenever rd_valid is 0.
- R11: When inj_valid=1 on an edge, inj_flip is XORed into the primary-bank word at inj_idx. The XOR is applied on top of any commit to the same word on that edge.
- R12: Only lanes whose req_be bit is 1 are written. Other lanes keep their previous contents, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of control and output registers |
| mode_full | input | 1 | 1 = full-capacity mode, 0 = protected mirrored mode; sampled with each request |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Word address |
| req_be | input | LANES | Per-lane write enables |
| req_wdata | input | LANES*LANE_W | Write data, LANE_W bits per lane |
| inj_valid | input | 1 | Apply the corrupt pattern this edge |
| inj_idx | input | ADDR_W-1 | Primary-bank word to corrupt |
| inj_flip | input | LANES*LANE_W | XOR pattern for the corrupt port |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | LANES*LANE_W | Read data |
| rd_fallback | output | LANES | Lanes taken from the secondary bank |

## Verification
The bench builds the block with ADDR_W=5, which gives 16 words per bank. A full-capacity fill can then cover every address, so every word the model later reads is defined. With banks this small, a random run of a few hundred requests hits the same index often enough to reach the cases that only arise when operations collide on one word. These are a read right after a write to that index, a corrupt landing on the same edge as a commit, and mode changes between a write and the read that follows it. LANES=4 and LANE_W=9 keep the flag vector small enough that the directed cases can reach every single-lane failure as well as the all-lanes failure.

// File: rtl/mbpf_pkg.sv
package mbpf_pkg;

   // Where a returned lane was sourced from
   typedef enum logic [1:0] {
      SRC_PRIMARY   = 2'd0,
      SRC_PENDING   = 2'd1,
      SRC_SECONDARY = 2'd2
   } lane_src_e;

endpackage

// File: rtl/mbpf_bank.sv
module mbpf_bank #(
   parameter int IDX_W  = 5,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [LANES-1:0]          wr_be,
   input  logic [LANES*LANE_W-1:0]   wr_data,
   input  logic                      inj_en,
   input  logic [IDX_W-1:0]          inj_idx,
   input  logic [LANES*LANE_W-1:0]   inj_flip,
   input  logic [IDX_W-1:0]          rd_idx,
   output logic [LANES*LANE_W-1:0]   rd_word
);
   localparam int DEPTH  = 1 << IDX_W;
   localparam int WORD_W = LANES * LANE_W;

   logic [WORD_W-1:0] store [DEPTH];
   logic [WORD_W-1:0] wr_cur;
   logic [WORD_W-1:0] wr_merged;
   logic [WORD_W-1:0] inj_base;

   assign wr_cur = store[wr_idx];

   // lane merge of the committing write
   always_comb begin
      wr_merged = wr_cur;
      for (int l = 0; l < LANES; l++) begin
         if (wr_be[l]) wr_merged[l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
      end
   end

   // corrupt pattern lands on top of a same-edge commit
   assign inj_base = (wr_en && (wr_idx == inj_idx)) ? wr_merged : store[inj_idx];

   always_ff @(posedge clk) begin
      if (wr_en)  store[wr_idx]  <= wr_merged;
      if (inj_en) store[inj_idx] <= inj_base ^ inj_flip;
   end

   // read with forwarding of the committing (pending) write
   always_comb begin
      rd_word = store[rd_idx];
      if (wr_en && (wr_idx == rd_idx)) begin
         for (int l = 0; l < LANES; l++) begin
            if (wr_be[l]) rd_word[l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
         end
      end
   end

endmodule

// File: rtl/mbpf_lane_pick.sv
module mbpf_lane_pick
   import mbpf_pkg::*;
#(
   parameter int LANE_W = 9
) (
   input  logic              protect,
   input  logic              pri_pending,
   input  logic [LANE_W-1:0] pri_lane,
   input  logic [LANE_W-1:0] sec_lane,
   output logic [LANE_W-1:0] out_lane,
   output logic              took_sec
);
   lane_src_e src;
   logic      pri_odd;

   assign pri_odd = ^pri_lane;

   always_comb begin
      if (!protect)          src = SRC_PRIMARY;
      else if (pri_pending)  src = SRC_PENDING;
      else if (pri_odd)      src = SRC_PRIMARY;
      else                   src = SRC_SECONDARY;
   end

   assign out_lane = (src == SRC_SECONDARY) ? sec_lane : pri_lane;
   assign took_sec = (src == SRC_SECONDARY);

endmodule

// File: rtl/mbpf_mem.sv
module mbpf_mem #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      mode_full,
   input  logic                      req_valid,
   input  logic                      req_write,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [LANES-1:0]          req_be,
   input  logic [LANES*LANE_W-1:0]   req_wdata,
   input  logic                      inj_valid,
   input  logic [ADDR_W-2:0]         inj_idx,
   input  logic [LANES*LANE_W-1:0]   inj_flip,
   output logic                      rd_valid,
   output logic [LANES*LANE_W-1:0]   rd_data,
   output logic [LANES-1:0]          rd_fallback
);
   localparam int IDX_W  = ADDR_W - 1;
   localparam int WORD_W = LANES * LANE_W;

   generate
      if (ADDR_W < 2)  begin : g_chk_addr  $error("ADDR_W must be at least 2");  end
      if (LANES < 1)   begin : g_chk_lanes $error("LANES must be at least 1");   end
      if (LANE_W < 2)  begin : g_chk_lanew $error("LANE_W must be at least 2");  end
   endgenerate

   // request decode
   logic             rd_req, wr_req, protect;
   logic [IDX_W-1:0] req_idx;
   logic             req_top;

   assign rd_req  = req_valid && !req_write;
   assign wr_req  = req_valid &&  req_write;
   assign protect = !mode_full;
   assign req_idx = req_addr[IDX_W-1:0];
   assign req_top = req_addr[ADDR_W-1];

   // one-entry write stage
   logic             wb_valid, wb_to_pri, wb_to_sec;
   logic [IDX_W-1:0] wb_idx;
   logic [LANES-1:0] wb_be;
   logic [WORD_W-1:0] wb_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid  <= 1'b0;
         wb_to_pri <= 1'b0;
         wb_to_sec <= 1'b0;
         wb_idx    <= '0;
         wb_be     <= '0;
         wb_data   <= '0;
      end else begin
         wb_valid <= wr_req;
         if (wr_req) begin
            wb_to_pri <= protect || !req_top;
            wb_to_sec <= protect ||  req_top;
            wb_idx    <= req_idx;
            wb_be     <= req_be;
            wb_data   <= req_wdata;
         end
      end
   end

   // banks: lower half primary, upper half secondary
   logic [WORD_W-1:0] pri_word, sec_word;

   mbpf_bank #(.IDX_W(IDX_W), .LANES(LANES), .LANE_W(LANE_W)) u_pri (
      .clk      (clk),
      .wr_en    (wb_valid && wb_to_pri),
      .wr_idx   (wb_idx),
      .wr_be    (wb_be),
      .wr_data  (wb_data),
      .inj_en   (inj_valid),
      .inj_idx  (inj_idx),
      .inj_flip (inj_flip),
      .rd_idx   (req_idx),
      .rd_word  (pri_word)
   );

   mbpf_bank #(.IDX_W(IDX_W), .LANES(LANES), .LANE_W(LANE_W)) u_sec (
      .clk      (clk),
      .wr_en    (wb_valid && wb_to_sec),
      .wr_idx   (wb_idx),
      .wr_be    (wb_be),
      .wr_data  (wb_data),
      .inj_en   (1'b0),
      .inj_idx  ({IDX_W{1'b0}}),
      .inj_flip ({WORD_W{1'b0}}),
      .rd_idx   (req_idx),
      .rd_word  (sec_word)
   );

   // lanes of the primary word supplied by the pending write
   logic [LANES-1:0]  pri_pending;
   logic [WORD_W-1:0] first_word;

   assign pri_pending = (wb_valid && wb_to_pri && (wb_idx == req_idx)) ? wb_be : '0;
   assign first_word  = (protect || !req_top) ? pri_word : sec_word;

   logic [WORD_W-1:0] pick_data;
   logic [LANES-1:0]  pick_sec;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         mbpf_lane_pick #(.LANE_W(LANE_W)) u_pick (
            .protect     (protect),
            .pri_pending (pri_pending[l]),
            .pri_lane    (first_word[l*LANE_W +: LANE_W]),
            .sec_lane    (sec_word[l*LANE_W +: LANE_W]),
            .out_lane    (pick_data[l*LANE_W +: LANE_W]),
            .took_sec    (pick_sec[l])
         );
      end
   endgenerate

   // registered read return
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid    <= 1'b0;
         rd_data     <= '0;
         rd_fallback <= '0;
      end else begin
         rd_valid    <= rd_req;
         rd_fallback <= rd_req ? pick_sec : '0;
         if (rd_req) rd_data <= pick_data;
      end
   end

   // assertions
   AST_FULL_NO_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && mode_full) |=> (rd_fallback == '0)); // R2

   AST_PENDING_NO_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && protect && (pri_pending == {LANES{1'b1}})) |=> (rd_fallback == '0)); // R8

   AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid); // R9

   AST_NO_READ_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid); // R9

   AST_IDLE_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_fallback == '0)); // R10

endmodule

// File: tb/mbpf_mem_tb.sv
`timescale 1ns/1ps
module mbpf_mem_tb;
   localparam int AW = 5;
   localparam int IW = AW - 1;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int WW = NL * LW;
   localparam int NW = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_full = 1'b1, req_valid = 1'b0, req_write = 1'b0, inj_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [NL-1:0] req_be = '0;
   logic [WW-1:0] req_wdata = '0, inj_flip = '0;
   logic [IW-1:0] inj_idx = '0;
   logic          rd_valid;
   logic [WW-1:0] rd_data;
   logic [NL-1:0] rd_fallback;

   always #2 clk = ~clk;

   mbpf_mem #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
      .clk(clk), .rst_n(rst_n), .mode_full(mode_full), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .inj_valid(inj_valid), .inj_idx(inj_idx), .inj_flip(inj_flip),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_fallback(rd_fallback));

   int checks = 0, fails = 0;
   bit done = 0;

   // behavioural model: flat word list plus a record of last edge's write
   logic [WW-1:0] mdl [NW];
   bit            pend_v = 0, pend_pri = 0;
   int            pend_idx = 0;
   logic [NL-1:0] pend_be = '0;

   function automatic logic [LW-1:0] lane(input logic [7:0] b, input bit good);
      lane = {(^b) ^ good, b};
   endfunction

   function automatic logic [WW-1:0] word(input logic [31:0] v, input logic [NL-1:0] good);
      logic [WW-1:0] w;
      for (int l = 0; l < NL; l++) w[l*LW +: LW] = lane(v[l*8 +: 8], good[l]);
      return w;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic mf, input logic rv, input logic rw, input logic [AW-1:0] a,
                       input logic [NL-1:0] be, input logic [WW-1:0] wd,
                       input logic iv, input logic [IW-1:0] ii, input logic [WW-1:0] fl,
                       input string tag);
      bit            ev;
      logic [WW-1:0] ed, p, s;
      logic [NL-1:0] ef;
      int            idx;
      mode_full = mf; req_valid = rv; req_write = rw; req_addr = a; req_be = be;
      req_wdata = wd; inj_valid = iv; inj_idx = ii; inj_flip = fl;
      // expectation from model state before this edge
      ev = rv && !rw; ed = '0; ef = '0;
      idx = int'(a[IW-1:0]);
      if (ev) begin
         if (mf) ed = mdl[a];
         else begin
            p = mdl[idx]; s = mdl[idx + NW/2];
            for (int l = 0; l < NL; l++) begin
               if (pend_v && pend_pri && pend_idx == idx && pend_be[l]) ed[l*LW +: LW] = p[l*LW +: LW];
               else if (^p[l*LW +: LW]) ed[l*LW +: LW] = p[l*LW +: LW];
               else begin ed[l*LW +: LW] = s[l*LW +: LW]; ef[l] = 1'b1; end
            end
         end
      end
      @(posedge clk);
      // model update: corrupt first, then the write
      if (iv) mdl[int'(ii)] = mdl[int'(ii)] ^ fl;
      pend_v = rv && rw;
      if (rv && rw) begin
         pend_idx = idx; pend_be = be; pend_pri = !mf || !a[AW-1];
         for (int l = 0; l < NL; l++) if (be[l]) begin
            if (mf) mdl[a][l*LW +: LW] = wd[l*LW +: LW];
            else begin
               mdl[idx][l*LW +: LW] = wd[l*LW +: LW];
               mdl[idx + NW/2][l*LW +: LW] = wd[l*LW +: LW];
            end
         end
      end
      @(negedge clk);
      check({tag, " R9 valid"}, 64'(rd_valid), 64'(ev));
      if (ev) begin
         check({tag, " data"}, 64'(rd_data), 64'(ed));
         check({tag, " R10 flags"}, 64'(rd_fallback), 64'(ef));
      end else check({tag, " R10 idle flags"}, 64'(rd_fallback), 64'(0));
   endtask

   task automatic wr(input logic mf, input logic [AW-1:0] a, input logic [NL-1:0] be,
                     input logic [WW-1:0] d, input string tag);
      step(mf, 1, 1, a, be, d, 0, '0, '0, tag);
   endtask
   task automatic rd(input logic mf, input logic [AW-1:0] a, input string tag);
      step(mf, 1, 0, a, '0, '0, 0, '0, '0, tag);
   endtask
   task automatic inj(input logic [IW-1:0] i, input logic [WW-1:0] f, input string tag);
      step(1, 0, 0, '0, '0, '0, 1, i, f, tag);
   endtask
   task automatic idle(input string tag);
      step(1, 0, 0, '0, '0, '0, 0, '0, '0, tag);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NW; i++) mdl[i] = '0;
      repeat (3) @(negedge clk);
      check("R1 reset valid", 64'(rd_valid), 64'(0));
      check("R1 reset flags", 64'(rd_fallback), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      // R2: full-capacity fill of every address, mixed parity, then read back
      for (int i = 0; i < NW; i++) wr(1, AW'(i), '1, word(32'hA5000000 + i * 32'h01030507, NL'(i)), "R2 fill");
      for (int i = 0; i < NW; i++) rd(1, AW'(i), "R2 read");
      // R3, R4: protected write through the upper alias, read through lower, then full mode
      wr(0, AW'(NW/2 + 3), '1, word(32'h11223344, '1), "R4 write");
      idle("R4 gap");
      rd(0, AW'(3), "R3 alias");
      rd(1, AW'(3), "R4 primary");
      rd(1, AW'(NW/2 + 3), "R4 secondary");
      // R5, R6: single lane corruption, each lane in turn
      for (int l = 0; l < NL; l++) begin
         inj(IW'(3), WW'(1) << (l * LW + 2), "R11 corrupt");
         rd(0, AW'(3), "R6 single lane");
         inj(IW'(3), WW'(1) << (l * LW + 2), "R11 undo");
      end
      // R5: two flips keep parity odd, no fallback
      inj(IW'(3), WW'(3), "R5 double flip");
      rd(0, AW'(3), "R5 odd kept");
      // R10: all lanes fail
      inj(IW'(3), {NL{9'h001}}, "R11 all");
      rd(0, AW'(3), "R10 all lanes");
      // R7: secondary holds bad parity on lane 0, primary lane 0 fails too
      wr(1, AW'(NW/2 + 3), 4'b0001, word(32'h000000F0, 4'b1110), "R7 bad secondary");
      idle("R7 gap");
      rd(0, AW'(3), "R7 unchecked");
      // R8: read right after a protected write of bad-parity data
      wr(0, AW'(5), '1, word(32'hCAFEF00D, '0), "R8 write");
      rd(0, AW'(5), "R8 pending");
      rd(0, AW'(5), "R8 committed");
      // R12: partial lane write, both modes
      wr(0, AW'(6), '1, word(32'h01020304, '1), "R12 base");
      wr(0, AW'(6), 4'b0101, word(32'hFFFFFFFF, '1), "R12 partial");
      idle("R12 gap");
      rd(0, AW'(6), "R12 protected");
      wr(1, AW'(7), 4'b1000, word(32'h99000000, '1), "R12 full partial");
      idle("R12 gap2");
      rd(1, AW'(7), "R12 full");
      // R11: corrupt on the edge that commits a write to the same word
      wr(0, AW'(8), '1, word(32'h55667788, '1), "R11 write");
      inj(IW'(8), WW'(1) << 4, "R11 same edge");
      rd(0, AW'(8), "R11 after commit");
      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0] & r[1], r[2] | r[3], r[4], AW'($urandom), NL'($urandom),
              word($urandom, NL'($urandom | $urandom)), (r[5:8] == 0), IW'($urandom),
              WW'(1) << ($urandom % WW), "R6 random");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule